// File: doc/BRIEF.md
# Debug Status and Instruction-Issue Controller

This block sits on the debug side of a core and answers a memory-mapped peripheral bus (APB-style setup and access phases). It holds one status and control word and admits debugger writes to an instruction slot. It keeps a flag that tracks whether the last instruction handed to the core has finished. When a new instruction write arrives while the core is still busy, a two-bit transfer mode decides what happens. In one mode the write is silently dropped. In the others the bus access is held in wait states until the core reports completion.

The block also carries the two debug-mode enables. Their readback is gated by an external enable input, while their programmed values are kept. A discard flag for imprecise aborts is set when the core enters debug state and cleared when it leaves. While that flag is set, an incoming imprecise abort is held back and recorded in a sticky bit. A second, internal write port for instructions bypasses the transfer mode entirely and is never held off.

Top module: `dbg_issue_ctrl`

## Requirements
- R1: After reset, the status word at byte offset 0x0 reads 0x0100_0000: only the completion flag (bit 24) is set, the transfer mode (bits 21:20) is 00, and both enables are 0. pready is high and neither effective mode output is asserted.
- R2: Completion flag (bit 24):
  - It reads 0 from the cycle after any instruction is issued, and returns to 1 after an instr_done pulse.
  - It is forced to 1 by dbg_enter.
  - If an issue and an instr_done fall in the same cycle, the flag reads 0.
- R3: In mode 00 or 11 (non-blocking), suppose a status read returned bit 24 = 0. The next write to the instruction slot at offset 0x4 then completes with no wait state and is not issued. A later status read that returns bit 24 = 1 cancels this pending drop.
- R4: In mode 01 or 10, an instruction-slot write made while bit 24 is 0 holds pready low. It completes, and issues the written word, in the first cycle after the instr_done pulse has been registered.
- R5: Internal port writes:
  - A core_itr_wr pulse issues core_itr_data in that same cycle, whatever the mode and completion flag.
  - A bus write to the instruction slot in that same access cycle gets one extra wait state, then proceeds under the mode rules.
- R6: Bit 19 (abort discard) becomes 1 after dbg_enter and 0 after dbg_exit.
- R7: Imprecise aborts:
  - While bit 19 is 0, abort_take follows imp_abort in the same cycle.
  - While bit 19 is 1, abort_take stays 0 and the sticky bit 7 is set.
  - Bit 7 stays set until reset.
- R8: Bits 15 (monitor enable) and 14 (halting enable) are writable. halt_eff is bit 14 AND dbg_en. mon_eff is bit 15 AND NOT bit 14 AND dbg_en.
- R9: While dbg_en is low, bits 15:14 read as 0 and the other bits read normally. The programmed enable values read back unchanged once dbg_en is high again.
- R10: Reads return 0 in every bit other than 24, 21:20, 19, 15:14 and 7. Writes change only bits 21:20, 15 and 14.
- R11: Reads never insert wait states, and a read of the instruction slot at offset 0x4 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | Bus write when high |
| paddr | input | ADDR_W | Byte address: 0x0 status word, 0x4 instruction slot |
| pwdata | input | DATA_W | Bus write data |
| prdata | output | DATA_W | Bus read data |
| pready | output | 1 | Low to insert a wait state |
| dbg_en | input | 1 | External debug enable that gates the mode enables |
| dbg_enter | input | 1 | Pulse: core enters debug state |
| dbg_exit | input | 1 | Pulse: core leaves debug state |
| instr_done | input | 1 | Pulse: core finished the issued instruction |
| core_itr_wr | input | 1 | Internal port instruction write strobe |
| core_itr_data | input | DATA_W | Internal port instruction word |
| issue_vld | output | 1 | Instruction handed to the core this cycle |
| issue_word | output | DATA_W | Instruction word handed to the core |
| imp_abort | input | 1 | Imprecise abort request from the memory system |
| abort_take | output | 1 | Imprecise abort forwarded to the core |
| halt_eff | output | 1 | Halting debug mode in effect |
| mon_eff | output | 1 | Monitor debug mode in effect |

## Verification
Two functions can land on the same clock edge.

The first case is the core reporting completion at the edge where a new instruction is accepted. The bench provokes it by raising instr_done in the access cycle of a non-blocking instruction write. It then judges the outcome by reading the status word: bit 24 must be 0, because the fresh issue outranks the completion.

The second case is an internal-port write colliding with a bus instruction write. The bench judges it by counting exactly one wait state, two issues, and the bus word last on issue_word.

// File: rtl/dbg_pkg.sv
package dbg_pkg;

  typedef enum logic [1:0] {
    XM_NONBLOCK = 2'b00,
    XM_STALL    = 2'b01,
    XM_FAST     = 2'b10,
    XM_RSVD     = 2'b11
  } xfer_mode_e;

  // Status word field positions (the debugger decodes these)
  localparam int unsigned SW_W       = 32;
  localparam int unsigned POS_DONE   = 24;
  localparam int unsigned POS_MODE_H = 21;
  localparam int unsigned POS_MODE_L = 20;
  localparam int unsigned POS_DISC   = 19;
  localparam int unsigned POS_MON    = 15;
  localparam int unsigned POS_HALT   = 14;
  localparam int unsigned POS_STICKY = 7;

  // Byte offsets of the two bus-visible slots
  localparam int unsigned OFS_STATUS = 0;
  localparam int unsigned OFS_ITR    = 4;

  function automatic logic mode_holds(input logic [1:0] m);
    return (m == XM_STALL) || (m == XM_FAST);
  endfunction

endpackage

// File: rtl/dbg_rst_sync.sv
module dbg_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sync_d = 1'b1;
    end else begin : g_many
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/dbg_apb_decode.sv
module dbg_apb_decode
  import dbg_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              pready,
  output logic              hit_status,
  output logic              st_rd_done,
  output logic              st_wr_done,
  output logic              itr_wr_req
);
  localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
  localparam logic [ADDR_W-1:0] A_ITR    = ADDR_W'(OFS_ITR);

  logic access;
  logic hit_itr;

  always_comb begin
    access     = psel & penable;
    hit_status = (paddr == A_STATUS);
    hit_itr    = (paddr == A_ITR);
    st_rd_done = access & ~pwrite & hit_status & pready;
    st_wr_done = access &  pwrite & hit_status & pready;
    itr_wr_req = access &  pwrite & hit_itr;
  end
endmodule

// File: rtl/dbg_issue_gate.sv
module dbg_issue_gate
  import dbg_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              itr_wr_req,
  input  logic [DATA_W-1:0] bus_word,
  input  logic [1:0]        mode,
  input  logic              st_rd_done,
  input  logic              dbg_enter,
  input  logic              instr_done,
  input  logic              core_wr,
  input  logic [DATA_W-1:0] core_word,
  output logic              itr_hold,
  output logic              issue_vld,
  output logic [DATA_W-1:0] issue_word,
  output logic              done_flag
);
  logic done_q, done_d, done_en;
  logic seen_q, seen_d, seen_en;
  logic holds_mode, itr_fire, nb_drop, bus_issue;

  // Gating of the bus instruction write
  always_comb begin
    holds_mode = mode_holds(mode);
    itr_hold   = itr_wr_req & ((holds_mode & ~done_q) | core_wr);
    itr_fire   = itr_wr_req & ~itr_hold;
    nb_drop    = itr_fire & ~holds_mode & seen_q;
    bus_issue  = itr_fire & ~nb_drop;
    issue_vld  = bus_issue | core_wr;
    issue_word = core_wr ? core_word : bus_word;
  end

  // Completion flag next state
  always_comb begin
    done_en = dbg_enter | issue_vld | instr_done;
    if (dbg_enter)      done_d = 1'b1;
    else if (issue_vld) done_d = 1'b0;
    else                done_d = 1'b1;
  end

  // Busy-seen-by-read next state
  always_comb begin
    seen_en = st_rd_done | itr_fire;
    seen_d  = st_rd_done ? ~done_q : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= 1'b1;
      seen_q <= 1'b0;
    end else begin
      if (done_en) done_q <= done_d;
      if (seen_en) seen_q <= seen_d;
    end
  end

  assign done_flag = done_q;
endmodule

// File: rtl/dbg_status_reg.sv
module dbg_status_reg
  import dbg_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [1:0]      wr_mode,
  input  logic            wr_mon,
  input  logic            wr_halt,
  input  logic            dbg_en,
  input  logic            dbg_enter,
  input  logic            dbg_exit,
  input  logic            imp_abort,
  input  logic            done_flag,
  output logic [1:0]      mode,
  output logic [SW_W-1:0] status_word,
  output logic            halt_eff,
  output logic            mon_eff,
  output logic            abort_take
);
  logic [1:0] mode_q;
  logic       mon_q, halt_q;
  logic       disc_q, disc_d, disc_en;
  logic       sticky_q, sticky_en;

  always_comb begin
    disc_en   = dbg_enter | dbg_exit;
    disc_d    = dbg_enter;
    sticky_en = imp_abort & disc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= XM_NONBLOCK;
      mon_q    <= 1'b0;
      halt_q   <= 1'b0;
      disc_q   <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      if (wr_en) begin
        mode_q <= wr_mode;
        mon_q  <= wr_mon;
        halt_q <= wr_halt;
      end
      if (disc_en)   disc_q   <= disc_d;
      if (sticky_en) sticky_q <= 1'b1;
    end
  end

  always_comb begin
    status_word                        = '0;
    status_word[POS_DONE]              = done_flag;
    status_word[POS_MODE_H:POS_MODE_L] = mode_q;
    status_word[POS_DISC]              = disc_q;
    status_word[POS_MON]               = mon_q & dbg_en;
    status_word[POS_HALT]              = halt_q & dbg_en;
    status_word[POS_STICKY]            = sticky_q;
    halt_eff   = halt_q & dbg_en;
    mon_eff    = mon_q & ~halt_q & dbg_en;
    abort_take = imp_abort & ~disc_q;
    mode       = mode_q;
  end
endmodule

// File: rtl/dbg_issue_ctrl.sv
module dbg_issue_ctrl
  import dbg_pkg::*;
#(
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ADDR_W    = 4,
  parameter int unsigned RST_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  output logic              pready,
  input  logic              dbg_en,
  input  logic              dbg_enter,
  input  logic              dbg_exit,
  input  logic              instr_done,
  input  logic              core_itr_wr,
  input  logic [DATA_W-1:0] core_itr_data,
  output logic              issue_vld,
  output logic [DATA_W-1:0] issue_word,
  input  logic              imp_abort,
  output logic              abort_take,
  output logic              halt_eff,
  output logic              mon_eff
);
  logic            rst_core_n;
  logic            hit_status, st_rd_done, st_wr_done, itr_wr_req;
  logic            itr_hold, done_flag;
  logic [1:0]      mode;
  logic [SW_W-1:0] status_word;

  dbg_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_core_n)
  );

  dbg_apb_decode #(.ADDR_W(ADDR_W)) u_dec (
    .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr),
    .pready(pready), .hit_status(hit_status), .st_rd_done(st_rd_done),
    .st_wr_done(st_wr_done), .itr_wr_req(itr_wr_req)
  );

  dbg_issue_gate #(.DATA_W(DATA_W)) u_gate (
    .clk(clk), .rst_n(rst_core_n), .itr_wr_req(itr_wr_req),
    .bus_word(pwdata), .mode(mode), .st_rd_done(st_rd_done),
    .dbg_enter(dbg_enter), .instr_done(instr_done),
    .core_wr(core_itr_wr), .core_word(core_itr_data),
    .itr_hold(itr_hold), .issue_vld(issue_vld), .issue_word(issue_word),
    .done_flag(done_flag)
  );

  dbg_status_reg u_sreg (
    .clk(clk), .rst_n(rst_core_n), .wr_en(st_wr_done),
    .wr_mode(pwdata[POS_MODE_H:POS_MODE_L]), .wr_mon(pwdata[POS_MON]),
    .wr_halt(pwdata[POS_HALT]), .dbg_en(dbg_en), .dbg_enter(dbg_enter),
    .dbg_exit(dbg_exit), .imp_abort(imp_abort), .done_flag(done_flag),
    .mode(mode), .status_word(status_word), .halt_eff(halt_eff),
    .mon_eff(mon_eff), .abort_take(abort_take)
  );

  always_comb begin
    pready = ~itr_hold;
    prdata = hit_status ? DATA_W'(status_word) : '0;
  end
endmodule

// File: rtl/dbg_issue_ctrl_chk.sv
module dbg_issue_ctrl_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic              pready,
  input logic [DATA_W-1:0] prdata,
  input logic              dbg_en,
  input logic              dbg_enter,
  input logic              dbg_exit,
  input logic              core_itr_wr,
  input logic              issue_vld,
  input logic              abort_take,
  input logic              halt_eff,
  input logic              mon_eff,
  input logic [31:0]       status_w
);
  localparam logic [31:0] LIVE = 32'h0138_C080;

  // R2
  issue_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    issue_vld && !dbg_enter |=> !status_w[24]);
  // R2
  enter_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_enter |=> status_w[24]);
  // R6
  enter_disc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_enter |=> status_w[19]);
  // R6
  exit_disc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_exit && !dbg_enter |=> !status_w[19]);
  // R7
  abort_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_w[19] |-> !abort_take);
  // R7
  sticky_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    status_w[7] |=> status_w[7]);
  // R8
  mode_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(halt_eff && mon_eff));
  // R9
  en_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_en |-> prdata[15:14] == 2'b00);
  // R10
  rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prdata & ~DATA_W'(LIVE)) == '0);
  // R11
  rd_nowait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    psel && penable && !pwrite |-> pready);
  // R5
  core_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    core_itr_wr |-> issue_vld);
endmodule

bind dbg_issue_ctrl dbg_issue_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .psel(psel), .penable(penable),
  .pwrite(pwrite), .pready(pready), .prdata(prdata), .dbg_en(dbg_en),
  .dbg_enter(dbg_enter), .dbg_exit(dbg_exit), .core_itr_wr(core_itr_wr),
  .issue_vld(issue_vld), .abort_take(abort_take), .halt_eff(halt_eff),
  .mon_eff(mon_eff), .status_w(status_word)
);

// File: tb/dbg_issue_ctrl_test.sv
module dbg_issue_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        psel, penable, pwrite;
  logic [3:0]  paddr;
  logic [31:0] pwdata, prdata;
  logic        pready;
  logic        dbg_en, dbg_enter, dbg_exit, instr_done;
  logic        core_itr_wr;
  logic [31:0] core_itr_data;
  logic        issue_vld;
  logic [31:0] issue_word;
  logic        imp_abort, abort_take, halt_eff, mon_eff;

  int n_chk = 0, n_fail = 0, n_issue = 0;
  logic [31:0] last_word = '0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  dbg_issue_ctrl uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .dbg_en(dbg_en), .dbg_enter(dbg_enter), .dbg_exit(dbg_exit),
    .instr_done(instr_done), .core_itr_wr(core_itr_wr),
    .core_itr_data(core_itr_data), .issue_vld(issue_vld),
    .issue_word(issue_word), .imp_abort(imp_abort), .abort_take(abort_take),
    .halt_eff(halt_eff), .mon_eff(mon_eff)
  );

  // issue monitor, sampled well after the falling edge
  always begin
    @(negedge clk); #3;
    if (issue_vld) begin n_issue++; last_word = issue_word; end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apb_write(input logic [3:0] a, input logic [31:0] d, output int waits);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1; waits = 0;
    #2;
    while (!pready && waits < 50) begin waits++; @(negedge clk); #2; end
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_read(input logic [3:0] a, output logic [31:0] d, output int waits);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1; waits = 0;
    #2;
    while (!pready && waits < 50) begin waits++; @(negedge clk); #2; end
    d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic pulse_done();
    @(negedge clk); instr_done = 1;
    @(negedge clk); instr_done = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d; int w;
    #2;
    chk(pready === 1'b1, "R1 pready", {31'b0, pready}, 32'h1);
    chk({halt_eff, mon_eff} === 2'b00, "R1 eff modes", {30'b0, halt_eff, mon_eff}, 32'h0);
    apb_read(4'h0, d, w);
    chk(d === 32'h0100_0000, "R1 status reset", d, 32'h0100_0000);
  endtask

  task automatic t_nonblock();
    logic [31:0] d; int w, n0;
    n0 = n_issue;
    apb_write(4'h4, 32'hA000_0001, w);
    chk(w == 0 && n_issue == n0 + 1 && last_word == 32'hA000_0001, "R3 first issue", last_word, 32'hA000_0001);
    apb_read(4'h0, d, w);
    chk(d[24] === 1'b0, "R2 busy after issue", d, 32'h0);
    n0 = n_issue;
    apb_write(4'h4, 32'hA000_0002, w);
    chk(w == 0 && n_issue == n0, "R3 dropped write", n_issue, n0);
    pulse_done();
    apb_read(4'h0, d, w);
    chk(d[24] === 1'b1, "R2 done after pulse", d, 32'h0100_0000);
    n0 = n_issue;
    apb_write(4'h4, 32'hA000_0003, w);
    chk(n_issue == n0 + 1 && last_word == 32'hA000_0003, "R3 drop cancelled", last_word, 32'hA000_0003);
    pulse_done();
    apb_write(4'h0, 32'h0030_0000, w);   // mode 11
    apb_write(4'h4, 32'hA000_0004, w);
    apb_read(4'h0, d, w);
    n0 = n_issue;
    apb_write(4'h4, 32'hA000_0005, w);
    chk(n_issue == n0, "R3 mode 11 drops", n_issue, n0);
    pulse_done();
    apb_write(4'h0, 32'h0, w);
  endtask

  task automatic t_stall(input logic [1:0] m);
    int w, n0;
    apb_write(4'h0, {10'b0, m, 20'b0}, w);
    apb_write(4'h4, 32'hB000_0001, w);
    n0 = n_issue;
    fork
      apb_write(4'h4, 32'hB000_0002, w);
      begin repeat (4) @(negedge clk); instr_done = 1; @(negedge clk); instr_done = 0; end
    join
    chk(w == 3, "R4 wait states", w, 3);
    chk(n_issue == n0 + 1 && last_word == 32'hB000_0002, "R4 issue after done", last_word, 32'hB000_0002);
    pulse_done();
    apb_write(4'h0, 32'h0, w);
  endtask

  task automatic t_overlap();
    logic [31:0] d; int w;
    apb_write(4'h4, 32'hC000_0001, w);
    fork
      apb_write(4'h4, 32'hC000_0002, w);
      begin @(negedge clk); @(negedge clk); instr_done = 1; @(negedge clk); instr_done = 0; end
    join
    chk(last_word == 32'hC000_0002, "R2 overlap issue", last_word, 32'hC000_0002);
    apb_read(4'h0, d, w);
    chk(d[24] === 1'b0, "R2 issue beats done", d, 32'h0);
    pulse_done();
  endtask

  task automatic t_internal();
    int w, n0;
    apb_write(4'h0, 32'h0010_0000, w);  // stall mode
    apb_write(4'h4, 32'hD000_0001, w);
    n0 = n_issue;
    @(negedge clk); core_itr_wr = 1; core_itr_data = 32'hD000_0002;
    @(negedge clk); core_itr_wr = 0;
    chk(n_issue == n0 + 1 && last_word == 32'hD000_0002, "R5 core port no stall", last_word, 32'hD000_0002);
    pulse_done();
    apb_write(4'h0, 32'h0, w);
    n0 = n_issue;
    fork
      apb_write(4'h4, 32'hD000_0003, w);
      begin @(negedge clk); @(negedge clk); core_itr_wr = 1; core_itr_data = 32'hD000_0004;
            @(negedge clk); core_itr_wr = 0; end
    join
    chk(w == 1, "R5 collision wait", w, 1);
    chk(n_issue == n0 + 2 && last_word == 32'hD000_0003, "R5 both issued", last_word, 32'hD000_0003);
    pulse_done();
  endtask

  task automatic t_debug();
    logic [31:0] d; int w;
    @(negedge clk); imp_abort = 1; #2;
    chk(abort_take === 1'b1, "R7 abort passes", {31'b0, abort_take}, 32'h1);
    @(negedge clk); imp_abort = 0;
    apb_write(4'h4, 32'hE000_0001, w);
    @(negedge clk); dbg_enter = 1; @(negedge clk); dbg_enter = 0;
    apb_read(4'h0, d, w);
    chk(d[24] === 1'b1 && d[19] === 1'b1, "R2 R6 enter", d, 32'h0108_0000);
    @(negedge clk); imp_abort = 1; #2;
    chk(abort_take === 1'b0, "R7 abort held", {31'b0, abort_take}, 32'h0);
    @(negedge clk); imp_abort = 0;
    @(negedge clk); dbg_exit = 1; @(negedge clk); dbg_exit = 0;
    apb_read(4'h0, d, w);
    chk(d === 32'h0100_0080, "R6 R7 exit sticky", d, 32'h0100_0080);
  endtask

  task automatic t_enables();
    logic [31:0] d; int w;
    apb_write(4'h0, 32'h0000_8000, w);
    #2;
    chk(mon_eff === 1'b1 && halt_eff === 1'b0, "R8 monitor", {30'b0, halt_eff, mon_eff}, 32'h1);
    apb_write(4'h0, 32'h0010_C000, w);
    #2;
    chk(mon_eff === 1'b0 && halt_eff === 1'b1, "R8 halting wins", {30'b0, halt_eff, mon_eff}, 32'h2);
    @(negedge clk); dbg_en = 0;
    apb_read(4'h0, d, w);
    chk(d === 32'h0110_0080, "R9 masked read", d, 32'h0110_0080);
    chk(halt_eff === 1'b0, "R9 halt gated", {31'b0, halt_eff}, 32'h0);
    @(negedge clk); dbg_en = 1;
    apb_read(4'h0, d, w);
    chk(d === 32'h0110_C080, "R9 values kept", d, 32'h0110_C080);
  endtask

  task automatic t_reserved();
    logic [31:0] d; int w;
    apb_write(4'h0, 32'hFFFF_FFFF, w);
    apb_read(4'h0, d, w);
    chk(d === 32'h0130_C080, "R10 reserved zero", d, 32'h0130_C080);
    chk(w == 0, "R11 no read wait", w, 0);
    apb_read(4'h4, d, w);
    chk(d === 32'h0, "R11 slot reads zero", d, 32'h0);
    apb_write(4'h0, 32'h0, w);
  endtask

  initial begin
    rst_n = 0; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    dbg_en = 1; dbg_enter = 0; dbg_exit = 0; instr_done = 0;
    core_itr_wr = 0; core_itr_data = '0; imp_abort = 0;
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_nonblock();
    t_stall(2'b01);
    t_stall(2'b10);
    t_overlap();
    t_internal();
    t_debug();
    t_enables();
    t_reserved();
    if (!done_flag) begin
      done_flag = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule